// File: doc/BRIEF.md
# Processor Core State Word

This block holds the 32-bit state word of a small processor core: the bits that say whether interrupts may be taken, whether the core runs in user mode, which byte order is live, whether translation is on, and so on. Software reads the word on `state_o` and replaces it through a write strobe. The core's control logic drives two hardware events: an exception-taken strobe and a return-from-exception strobe.

When an exception is taken, the block copies the current word into a save register. It then puts the word into handler state: most mode bits are cleared, and the exception byte-order bit is copied into the live byte-order bit. On return, the saved copy is loaded back into the live word. The interrupt-vector-prefix bit is set from a configuration input on a hard reset, and that value is latched. A later soft reset brings the prefix back to the latched value. Two registered outputs tell the rest of the core whether external and timer interrupts, and machine checks, may currently be accepted.

Top module: `core_state_reg`

## Requirements
- R1: `state_o` bit numbers are little-endian indices (bit 31 = MSB). The implemented bits and their meanings are: 16 exception byte order, 15 interrupt enable, 14 user mode, 13 FPU enable, 12 machine-check enable, 10 single-step trace, 9 branch trace, 6 vector prefix, 5 instruction translation, 4 data translation, 1 recoverable, 0 live byte order. Every other bit always reads 0.
- R2: When `hard_rst` is sampled high, the next word has bit 6 equal to `cfg_prefix` and every other bit 0. The save register is cleared, and `cfg_prefix` is latched as the soft-reset prefix.
- R3: When `soft_rst` is sampled high without `hard_rst`, the next word has bit 6 equal to the prefix latched at the last hard reset and every other bit 0. The save register is cleared, and the current `cfg_prefix` has no effect.
- R4: When `wr_en` is sampled high and no reset or exception event is present, the word becomes `wr_data` with the reserved bits discarded.
- R5: When `xcpt_take` is sampled high and no reset is present, `save_o` becomes the word as it was before that edge.
- R6: On exception entry, bits 15, 14, 13, 10, 9, 5, 4 and 1 become 0. Bit 0 takes the old value of bit 16. Bits 16, 12 and 6 keep their values.
- R7: When `xcpt_ret` is sampled high and no reset or exception is present, the word becomes the contents of the save register.
- R8: Priority per edge: hard reset, then soft reset, then exception entry, then return, then software write.
- R9: `irq_enable_o` equals bit 15 of the word and changes at the same edge as the word.
- R10: `mchk_enable_o` equals bit 12 of the word and changes at the same edge as the word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| hard_rst | input | 1 | Synchronous hard reset, active high |
| soft_rst | input | 1 | Synchronous soft reset, active high |
| cfg_prefix | input | 1 | Vector-prefix value captured on hard reset |
| wr_en | input | 1 | Software write strobe |
| wr_data | input | 32 | Software write data |
| xcpt_take | input | 1 | Exception-taken strobe |
| xcpt_ret | input | 1 | Return-from-exception strobe |
| state_o | output | 32 | Live state word |
| save_o | output | 32 | Save register |
| irq_enable_o | output | 1 | External and timer interrupts may be accepted |
| mchk_enable_o | output | 1 | Machine checks may be accepted |

## Verification
Every result is due exactly one clock edge after the stimulus: the word, the save register and both enable outputs are all registered on the edge that samples the strobes. The bench drives inputs on the falling edge and checks on the next falling edge, after one rising edge. The sweep covers all 4096 patterns of the implemented bits. Each pattern goes through write, exception entry and return, with three checks due one, two and three edges after the write. Priority and reset cases use single-edge stimuli and are checked on the following falling edge.

// File: rtl/core_state_pkg.sv
package core_state_pkg;
  parameter int unsigned XLEN = 32;

  // little-endian indices of the implemented fields
  localparam int unsigned B_XEND  = 16;
  localparam int unsigned B_INTEN = 15;
  localparam int unsigned B_USER  = 14;
  localparam int unsigned B_FPU   = 13;
  localparam int unsigned B_MCHK  = 12;
  localparam int unsigned B_STEP  = 10;
  localparam int unsigned B_BRTR  = 9;
  localparam int unsigned B_PFX   = 6;
  localparam int unsigned B_IXL   = 5;
  localparam int unsigned B_DXL   = 4;
  localparam int unsigned B_RECOV = 1;
  localparam int unsigned B_LEND  = 0;

  localparam logic [XLEN-1:0] ONE = XLEN'(1);

  localparam logic [XLEN-1:0] IMPL_MASK =
      (ONE << B_XEND) | (ONE << B_INTEN) | (ONE << B_USER) | (ONE << B_FPU) |
      (ONE << B_MCHK) | (ONE << B_STEP)  | (ONE << B_BRTR) | (ONE << B_PFX) |
      (ONE << B_IXL)  | (ONE << B_DXL)   | (ONE << B_RECOV) | (ONE << B_LEND);

  // fields forced to zero on exception entry
  localparam logic [XLEN-1:0] XCPT_CLR =
      (ONE << B_INTEN) | (ONE << B_USER) | (ONE << B_FPU) | (ONE << B_STEP) |
      (ONE << B_BRTR)  | (ONE << B_IXL)  | (ONE << B_DXL) | (ONE << B_RECOV);

  typedef logic [XLEN-1:0] word_t;
endpackage

// File: rtl/csr_prefix_latch.sv
module csr_prefix_latch (
  input  logic clk,
  input  logic hard_rst,
  input  logic cfg_prefix,
  output logic prefix_q
);
  always_ff @(posedge clk) begin
    if (hard_rst) prefix_q <= cfg_prefix;
  end

  AST_PFX_HOLD: assert property (@(posedge clk) disable iff (hard_rst)
    $past(hard_rst) |-> prefix_q == $past(cfg_prefix)); // R2
endmodule

// File: rtl/csr_save_word.sv
module csr_save_word
  import core_state_pkg::*;
(
  input  logic  clk,
  input  logic  hard_rst,
  input  logic  soft_rst,
  input  logic  xcpt_take,
  input  word_t state_q,
  output word_t save_q
);
  always_ff @(posedge clk) begin
    if (hard_rst || soft_rst) save_q <= '0;
    else if (xcpt_take)       save_q <= state_q & IMPL_MASK;
  end

  AST_SAVE_CAPTURE: assert property (@(posedge clk) disable iff (hard_rst || soft_rst)
    xcpt_take |=> save_q == $past(state_q)); // R5
endmodule

// File: rtl/csr_state_word.sv
module csr_state_word
  import core_state_pkg::*;
(
  input  logic  clk,
  input  logic  hard_rst,
  input  logic  soft_rst,
  input  logic  cfg_prefix,
  input  logic  prefix_q,
  input  logic  wr_en,
  input  word_t wr_data,
  input  logic  xcpt_take,
  input  logic  xcpt_ret,
  input  word_t save_q,
  output word_t state_nxt,
  output word_t state_q
);
  word_t raw;

  always_comb begin
    raw = state_q;
    if (hard_rst) begin
      raw        = '0;
      raw[B_PFX] = cfg_prefix;
    end else if (soft_rst) begin
      raw        = '0;
      raw[B_PFX] = prefix_q;
    end else if (xcpt_take) begin
      raw         = state_q & ~XCPT_CLR;
      raw[B_LEND] = state_q[B_XEND];
    end else if (xcpt_ret) begin
      raw = save_q;
    end else if (wr_en) begin
      raw = wr_data;
    end
    state_nxt = raw & IMPL_MASK;
  end

  always_ff @(posedge clk) begin
    state_q <= state_nxt;
  end

  AST_HARD_LOAD: assert property (@(posedge clk)
    hard_rst |=> state_q == ($past(cfg_prefix) ? (ONE << B_PFX) : '0)); // R2
  AST_SOFT_LOAD: assert property (@(posedge clk) disable iff (hard_rst)
    soft_rst |=> state_q == ($past(prefix_q) ? (ONE << B_PFX) : '0)); // R3
  AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (hard_rst)
    (state_q & ~IMPL_MASK) == '0); // R1
  AST_SW_WRITE: assert property (@(posedge clk) disable iff (hard_rst || soft_rst)
    (wr_en && !xcpt_take && !xcpt_ret) |=> state_q == ($past(wr_data) & IMPL_MASK)); // R4
  AST_XCPT_ENTRY: assert property (@(posedge clk) disable iff (hard_rst || soft_rst)
    xcpt_take |=> ((state_q & XCPT_CLR) == '0) &&
                  (state_q[B_LEND] == $past(state_q[B_XEND])) &&
                  (state_q[B_MCHK] == $past(state_q[B_MCHK]))); // R6
  AST_XCPT_RETURN: assert property (@(posedge clk) disable iff (hard_rst || soft_rst)
    (xcpt_ret && !xcpt_take) |=> state_q == $past(save_q)); // R7
  AST_TAKE_OVER_WRITE: assert property (@(posedge clk) disable iff (hard_rst || soft_rst)
    (xcpt_take && wr_en) |=> state_q[B_INTEN] == 1'b0); // R8
endmodule

// File: rtl/core_state_reg.sv
module core_state_reg
  import core_state_pkg::*;
(
  input  logic            clk,
  input  logic            hard_rst,
  input  logic            soft_rst,
  input  logic            cfg_prefix,
  input  logic            wr_en,
  input  logic [XLEN-1:0] wr_data,
  input  logic            xcpt_take,
  input  logic            xcpt_ret,
  output logic [XLEN-1:0] state_o,
  output logic [XLEN-1:0] save_o,
  output logic            irq_enable_o,
  output logic            mchk_enable_o
);
  word_t state_q, state_nxt, save_q;
  logic  prefix_q;
  logic  irq_q, mchk_q;

  csr_prefix_latch u_pfx (
    .clk(clk), .hard_rst(hard_rst), .cfg_prefix(cfg_prefix), .prefix_q(prefix_q)
  );

  csr_state_word u_word (
    .clk(clk), .hard_rst(hard_rst), .soft_rst(soft_rst), .cfg_prefix(cfg_prefix),
    .prefix_q(prefix_q), .wr_en(wr_en), .wr_data(wr_data), .xcpt_take(xcpt_take),
    .xcpt_ret(xcpt_ret), .save_q(save_q), .state_nxt(state_nxt), .state_q(state_q)
  );

  csr_save_word u_save (
    .clk(clk), .hard_rst(hard_rst), .soft_rst(soft_rst), .xcpt_take(xcpt_take),
    .state_q(state_q), .save_q(save_q)
  );

  // enable outputs registered in parallel with the word
  always_ff @(posedge clk) begin
    irq_q  <= state_nxt[B_INTEN];
    mchk_q <= state_nxt[B_MCHK];
  end

  assign state_o       = state_q;
  assign save_o        = save_q;
  assign irq_enable_o  = irq_q;
  assign mchk_enable_o = mchk_q;

  AST_IRQ_TRACK: assert property (@(posedge clk) disable iff (hard_rst)
    irq_enable_o == state_o[B_INTEN]); // R9
  AST_MCHK_TRACK: assert property (@(posedge clk) disable iff (hard_rst)
    mchk_enable_o == state_o[B_MCHK]); // R10
endmodule

// File: tb/core_state_reg_test.sv
module core_state_reg_test;
  logic        clk = 1'b0;
  logic        hard_rst, soft_rst, cfg_prefix, wr_en, xcpt_take, xcpt_ret;
  logic [31:0] wr_data;
  logic [31:0] state_o, save_o;
  logic        irq_enable_o, mchk_enable_o;
  int checks = 0;
  int errors = 0;

  localparam logic [31:0] MASK = 32'h0001_F673;
  localparam logic [31:0] CLR  = 32'h0000_E632;

  always #10 clk = ~clk;

  core_state_reg uut (
    .clk(clk), .hard_rst(hard_rst), .soft_rst(soft_rst), .cfg_prefix(cfg_prefix),
    .wr_en(wr_en), .wr_data(wr_data), .xcpt_take(xcpt_take), .xcpt_ret(xcpt_ret),
    .state_o(state_o), .save_o(save_o), .irq_enable_o(irq_enable_o),
    .mchk_enable_o(mchk_enable_o)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic idle();
    hard_rst = 0; soft_rst = 0; wr_en = 0; xcpt_take = 0; xcpt_ret = 0;
  endtask

  function automatic logic [31:0] spread(input logic [11:0] p);
    int pos[12] = '{16, 15, 14, 13, 12, 10, 9, 6, 5, 4, 1, 0};
    logic [31:0] w = '0;
    for (int k = 0; k < 12; k++) w[pos[k]] = p[k];
    return w;
  endfunction

  function automatic logic [31:0] entry(input logic [31:0] s);
    logic [31:0] r = s & ~CLR;
    r[0] = s[16];
    return r;
  endfunction

  initial begin
    #(20 * 200000);
    checks++; errors++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] s;
    idle(); wr_data = '0; cfg_prefix = 1'b1; hard_rst = 1;
    tick(); idle();
    chk("R2 hard reset word", state_o, 32'h40);
    chk("R2 hard reset save", save_o, 32'h0);
    chk("R9 irq after reset", {31'd0, irq_enable_o}, 32'd0);

    // R3: soft reset restores latched prefix, ignores current cfg_prefix
    wr_en = 1; wr_data = 32'hFFFF_FFFF; tick(); idle();
    chk("R1 reserved read zero", state_o, MASK);
    cfg_prefix = 0; soft_rst = 1; tick(); idle();
    chk("R3 soft reset prefix 1", state_o, 32'h40);
    hard_rst = 1; tick(); idle();
    chk("R2 hard reset prefix 0", state_o, 32'h0);
    cfg_prefix = 1; wr_en = 1; wr_data = MASK; tick(); idle();
    xcpt_take = 1; tick(); idle();
    soft_rst = 1; tick(); idle();
    chk("R3 soft reset prefix 0", state_o, 32'h0);
    chk("R3 soft reset clears save", save_o, 32'h0);

    // R8 priority cases
    wr_en = 1; wr_data = MASK; tick(); idle();
    hard_rst = 1; soft_rst = 1; xcpt_take = 1; wr_en = 1; wr_data = 32'h0; cfg_prefix = 1;
    tick(); idle();
    chk("R8 hard over all", state_o, 32'h40);
    wr_en = 1; wr_data = MASK; tick(); idle();
    soft_rst = 1; xcpt_take = 1; xcpt_ret = 1; tick(); idle();
    chk("R8 soft over exception", state_o, 32'h40);
    wr_en = 1; wr_data = MASK; tick(); idle();
    xcpt_take = 1; wr_en = 1; wr_data = 32'h0000_8000; tick(); idle();
    chk("R8 exception over write", state_o, entry(MASK));
    chk("R8 exception over write save", save_o, MASK);
    xcpt_take = 1; xcpt_ret = 1; tick(); idle();
    chk("R8 exception over return", save_o, entry(MASK));
    xcpt_ret = 1; wr_en = 1; wr_data = 32'h0; tick(); idle();
    chk("R8 return over write", state_o, entry(MASK));

    // exhaustive sweep of implemented-bit patterns
    for (int p = 0; p < 4096; p++) begin
      s = spread(p[11:0]);
      wr_en = 1; wr_data = s | ~MASK; tick(); idle();
      chk("R4 write discards reserved", state_o, s);
      chk("R10 mchk tracks", {31'd0, mchk_enable_o}, {31'd0, s[12]});
      xcpt_take = 1; tick(); idle();
      chk("R5 save captures word", save_o, s);
      chk("R6 entry fields", state_o, entry(s));
      chk("R9 irq off in handler", {31'd0, irq_enable_o}, 32'd0);
      xcpt_ret = 1; tick(); idle();
      chk("R7 return restores", state_o, s);
      chk("R9 irq after return", {31'd0, irq_enable_o}, {31'd0, s[15]});
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule